// File: doc/BRIEF.md
# TDMA Superframe Window Scheduler

This block keeps time inside a periodic superframe for a multi-node burst network with one master and several slaves, and decides the cycles in which a burst may begin. A programmable divider turns the processing clock into a one-microsecond tick, and a microsecond counter runs from each start-of-superframe event. On the master the counter wraps by itself at the configured period and the wrap is the superframe start. On a slave a start-of-superframe pulse from the receive side (first frame preamble detected) resynchronises the counter. Without such a pulse the slave counter free-runs at the same period.

Two channel controllers sit on the shared counter, one for transmit and one for receive. A pending transmit frame is granted only when the counter lies inside the transmit window. A pending receive start is accepted only inside the receive window. Each direction starts at most one frame per superframe, raises a busy flag, and may run past the window end until its end-of-frame pulse. Continuous mode drops the windows and the once-per-superframe limit. In half-duplex mode the two directions lock each other out. The block carries no data stream: every pin is a plain control or status level or a one-cycle pulse.

Top module: `tdma_sched`

## Requirements
- R1: During and right after reset, `sof_o`, `tx_grant_o`, `tx_busy_o`, `rx_accept_o`, `rx_busy_o` are 0 and `us_count_o` is 0.
- R2: `us_count_o` advances by one every `cfg_us_div` clock cycles. A divider value of 0 acts as 1.
- R3: With `cfg_master`=1, the counter returns to 0 after reaching `cfg_period`-1, and `sof_o` pulses for one cycle on each wrap, so pulses are `cfg_period`*`cfg_us_div` cycles apart. `sof_o` is high only when `us_count_o` is 0. `rx_sof_i` has no effect on a master.
- R4: With `cfg_master`=0, a pulse on `rx_sof_i` gives `sof_o`=1 and `us_count_o`=0 in the following cycle, whatever the counter held.
- R5: A slave that receives no `rx_sof_i` keeps wrapping at `cfg_period` exactly like a master.
- R6: `tx_grant_o` pulses one cycle after an evaluation in which `tx_req_i`=1 and the counter lies in [`cfg_tx_start`, `cfg_tx_end`). On a master the start bound is taken as 0.
- R7: At most one transmit grant and one receive accept are issued per superframe. The allowance returns at the next `sof_o`.
- R8: `tx_busy_o` rises together with `tx_grant_o`. It stays high past the window end and falls one cycle after a `tx_eof_i` pulse. `tx_grant_o` is never high two cycles running.
- R9: With `cfg_continuous`=1 a request is granted whatever the counter value, and again after each end of frame within the same superframe.
- R10: `rx_accept_o` and `rx_busy_o` follow `rx_start_i` under the same rules, using [`cfg_rx_start`, `cfg_rx_end`). `rx_eof_i` ends the reception.
- R11: With `cfg_full_duplex`=0, no grant is issued while `rx_busy_o` is high, and no accept is issued while `tx_busy_o` is high. On a simultaneous request the reception wins. With `cfg_full_duplex`=1 both may start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processing clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_master | input | 1 | 1 = master (generates superframe), 0 = slave |
| cfg_continuous | input | 1 | 1 = ignore windows and per-superframe limit |
| cfg_full_duplex | input | 1 | 1 = transmit and receive may overlap |
| cfg_us_div | input | DIV_W | clock cycles per microsecond |
| cfg_period | input | TIME_W | superframe length in microseconds |
| cfg_tx_start | input | TIME_W | transmit window start, microseconds |
| cfg_tx_end | input | TIME_W | transmit window end (exclusive) |
| cfg_rx_start | input | TIME_W | receive window start, microseconds |
| cfg_rx_end | input | TIME_W | receive window end (exclusive) |
| rx_sof_i | input | 1 | slave superframe-start pulse from preamble detection |
| tx_req_i | input | 1 | a transmit frame is pending |
| tx_eof_i | input | 1 | transmit frame finished |
| rx_start_i | input | 1 | a reception wants to begin |
| rx_eof_i | input | 1 | reception finished |
| sof_o | output | 1 | start-of-superframe pulse |
| us_count_o | output | TIME_W | microseconds since superframe start |
| tx_grant_o | output | 1 | transmit may begin now (pulse) |
| tx_busy_o | output | 1 | transmit frame in progress |
| rx_accept_o | output | 1 | reception accepted (pulse) |
| rx_busy_o | output | 1 | reception in progress |

## Verification
Every result appears one register after its cause. A grant, an accept or a resync is visible in the cycle after the request or pulse is presented, and a busy flag falls in the cycle after its end-of-frame pulse. The counter moves every divider cycles and the superframe pulse repeats every period times divider cycles. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands exactly one rising edge after its stimulus. Window checks wait for the first cycle of a given counter value and read the counter at the grant, so the window bounds are checked to the exact microsecond.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  typedef enum logic { ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1 } role_e;

  localparam int unsigned TDMA_TIME_W = 24;
  localparam int unsigned TDMA_DIV_W  = 16;
endpackage

// File: rtl/tdma_us_tick.sv
module tdma_us_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last   = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (restart_i)  cnt_q <= '0;
    else if (tick_o)     cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tdma_sf_timer.sv
module tdma_sf_timer #(
  parameter int unsigned TIME_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              resync_i,
  input  logic [TIME_W-1:0] period_i,
  output logic [TIME_W-1:0] us_o,
  output logic              sof_o
);
  logic [TIME_W-1:0] us_q;
  logic [TIME_W-1:0] top;
  logic              sof_q;

  assign top = (period_i == '0) ? '0 : period_i - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      us_q  <= '0;
      sof_q <= 1'b0;
    end else if (resync_i) begin
      us_q  <= '0;
      sof_q <= 1'b1;
    end else begin
      sof_q <= 1'b0;
      if (tick_i) begin
        if (us_q >= top) begin
          us_q  <= '0;
          sof_q <= 1'b1;
        end else begin
          us_q <= us_q + 1'b1;
        end
      end
    end
  end

  assign us_o  = us_q;
  assign sof_o = sof_q;
endmodule

// File: rtl/tdma_chan.sv
module tdma_chan #(
  parameter int unsigned TIME_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cont_i,
  input  logic              sof_i,
  input  logic [TIME_W-1:0] cur_i,
  input  logic [TIME_W-1:0] lo_i,
  input  logic [TIME_W-1:0] hi_i,
  input  logic              req_i,
  input  logic              done_i,
  input  logic              block_i,
  output logic              start_d_o,
  output logic              start_o,
  output logic              busy_o
);
  logic in_win, fresh;
  logic start_q, busy_q, used_q;

  assign in_win    = cont_i | ((cur_i >= lo_i) && (cur_i < hi_i));
  assign fresh     = cont_i | sof_i | ~used_q;
  assign start_d_o = req_i & ~busy_q & in_win & fresh & ~block_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      used_q  <= 1'b0;
    end else begin
      start_q <= start_d_o;
      if (start_d_o)   busy_q <= 1'b1;
      else if (done_i) busy_q <= 1'b0;
      if (start_d_o)   used_q <= 1'b1;
      else if (sof_i)  used_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/tdma_sched.sv
module tdma_sched #(
  parameter int unsigned TIME_W = tdma_pkg::TDMA_TIME_W,
  parameter int unsigned DIV_W  = tdma_pkg::TDMA_DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_continuous,
  input  logic              cfg_full_duplex,
  input  logic [DIV_W-1:0]  cfg_us_div,
  input  logic [TIME_W-1:0] cfg_period,
  input  logic [TIME_W-1:0] cfg_tx_start,
  input  logic [TIME_W-1:0] cfg_tx_end,
  input  logic [TIME_W-1:0] cfg_rx_start,
  input  logic [TIME_W-1:0] cfg_rx_end,
  input  logic              rx_sof_i,
  input  logic              tx_req_i,
  input  logic              tx_eof_i,
  input  logic              rx_start_i,
  input  logic              rx_eof_i,
  output logic              sof_o,
  output logic [TIME_W-1:0] us_count_o,
  output logic              tx_grant_o,
  output logic              tx_busy_o,
  output logic              rx_accept_o,
  output logic              rx_busy_o
);
  import tdma_pkg::*;

  role_e             role;
  logic              resync, tick, sof;
  logic [TIME_W-1:0] us;
  logic [TIME_W-1:0] tx_lo;
  logic              tx_start_d, rx_start_d;
  logic              tx_block, rx_block;

  assign role   = role_e'(cfg_master);
  assign resync = (role == ROLE_SLAVE) & rx_sof_i;
  assign tx_lo  = (role == ROLE_MASTER) ? '0 : cfg_tx_start;

  // half duplex: reception has priority on a tie
  assign rx_block = ~cfg_full_duplex & tx_busy_o;
  assign tx_block = ~cfg_full_duplex & (rx_busy_o | rx_start_d);

  tdma_us_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_i(cfg_us_div),
    .restart_i(resync), .tick_o(tick)
  );

  tdma_sf_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .resync_i(resync),
    .period_i(cfg_period), .us_o(us), .sof_o(sof)
  );

  tdma_chan #(.TIME_W(TIME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cont_i(cfg_continuous), .sof_i(sof),
    .cur_i(us), .lo_i(tx_lo), .hi_i(cfg_tx_end),
    .req_i(tx_req_i), .done_i(tx_eof_i), .block_i(tx_block),
    .start_d_o(tx_start_d), .start_o(tx_grant_o), .busy_o(tx_busy_o)
  );

  tdma_chan #(.TIME_W(TIME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cont_i(cfg_continuous), .sof_i(sof),
    .cur_i(us), .lo_i(cfg_rx_start), .hi_i(cfg_rx_end),
    .req_i(rx_start_i), .done_i(rx_eof_i), .block_i(rx_block),
    .start_d_o(rx_start_d), .start_o(rx_accept_o), .busy_o(rx_busy_o)
  );

  assign sof_o      = sof;
  assign us_count_o = us;
endmodule

// File: rtl/tdma_sched_chk.sv
module tdma_sched_chk #(
  parameter int unsigned TIME_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_master,
  input logic              cfg_full_duplex,
  input logic              rx_sof_i,
  input logic              tx_eof_i,
  input logic              sof_o,
  input logic [TIME_W-1:0] us_count_o,
  input logic              tx_grant_o,
  input logic              tx_busy_o,
  input logic              rx_accept_o,
  input logic              rx_busy_o
);
  // R3
  sof_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> (us_count_o == '0));

  // R4
  slave_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && rx_sof_i) |=> (sof_o && us_count_o == '0));

  // R8
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant_o |-> tx_busy_o);

  // R8
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant_o |=> !tx_grant_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy_o && !tx_eof_i) |=> tx_busy_o);

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept_o |-> rx_busy_o);

  // R11
  half_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_full_duplex && $stable(cfg_full_duplex)) |-> !(tx_busy_o && rx_busy_o));
endmodule

bind tdma_sched tdma_sched_chk #(.TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
  .cfg_full_duplex(cfg_full_duplex), .rx_sof_i(rx_sof_i),
  .tx_eof_i(tx_eof_i), .sof_o(sof_o), .us_count_o(us_count_o),
  .tx_grant_o(tx_grant_o), .tx_busy_o(tx_busy_o),
  .rx_accept_o(rx_accept_o), .rx_busy_o(rx_busy_o)
);

// File: tb/tdma_sched_tb.sv
module tdma_sched_tb;
  localparam int TW = 24;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b0, cfg_continuous = 1'b0, cfg_full_duplex = 1'b0;
  logic [DW-1:0] cfg_us_div = 16'd4;
  logic [TW-1:0] cfg_period = 24'd40;
  logic [TW-1:0] cfg_tx_start = 24'd10, cfg_tx_end = 24'd20;
  logic [TW-1:0] cfg_rx_start = 24'd5,  cfg_rx_end = 24'd30;
  logic rx_sof_i = 1'b0, tx_req_i = 1'b0, tx_eof_i = 1'b0;
  logic rx_start_i = 1'b0, rx_eof_i = 1'b0;
  logic sof_o, tx_grant_o, tx_busy_o, rx_accept_o, rx_busy_o;
  logic [TW-1:0] us_count_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  tdma_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .cfg_continuous(cfg_continuous), .cfg_full_duplex(cfg_full_duplex),
    .cfg_us_div(cfg_us_div), .cfg_period(cfg_period),
    .cfg_tx_start(cfg_tx_start), .cfg_tx_end(cfg_tx_end),
    .cfg_rx_start(cfg_rx_start), .cfg_rx_end(cfg_rx_end),
    .rx_sof_i(rx_sof_i), .tx_req_i(tx_req_i), .tx_eof_i(tx_eof_i),
    .rx_start_i(rx_start_i), .rx_eof_i(rx_eof_i), .sof_o(sof_o),
    .us_count_o(us_count_o), .tx_grant_o(tx_grant_o), .tx_busy_o(tx_busy_o),
    .rx_accept_o(rx_accept_o), .rx_busy_o(rx_busy_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset(input logic master, input logic cont, input logic full,
                          input logic [DW-1:0] div);
    tx_req_i = 0; tx_eof_i = 0; rx_start_i = 0; rx_eof_i = 0; rx_sof_i = 0;
    cfg_master = master; cfg_continuous = cont; cfg_full_duplex = full;
    cfg_us_div = div;
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
  endtask

  // advance to the first cycle in which the counter shows v
  task automatic wait_edge(input int v);
    int prev;
    prev = int'(us_count_o);
    for (int i = 0; i < 2000; i++) begin
      step();
      if (int'(us_count_o) == v && prev != v) return;
      prev = int'(us_count_o);
    end
  endtask

  task automatic cycles_to_sof(output int n);
    n = 0;
    do begin step(); n++; end while (!sof_o && n < 2000);
  endtask

  task automatic t_reset();
    tx_req_i = 0; rst_n = 0;
    repeat (2) step();
    check("R1", "outputs in reset",
          int'({sof_o, tx_grant_o, tx_busy_o, rx_accept_o, rx_busy_o}), 0);
    check("R1", "counter in reset", int'(us_count_o), 0);
    rst_n = 1; step();
    check("R1", "outputs after reset",
          int'({sof_o, tx_grant_o, tx_busy_o, rx_accept_o, rx_busy_o}), 0);
  endtask

  task automatic t_divider();
    int n;
    do_reset(1, 0, 0, 16'd4);
    wait_edge(3);
    n = 0;
    do begin step(); n++; end while (us_count_o == 3 && n < 100);
    check("R2", "cycles per us (div 4)", n, 4);
    do_reset(1, 0, 0, 16'd0);
    wait_edge(3);
    step();
    check("R2", "div 0 acts as 1", int'(us_count_o), 4);
  endtask

  task automatic t_master();
    int n;
    do_reset(1, 0, 0, 16'd4);
    cycles_to_sof(n);
    check("R3", "counter at sof", int'(us_count_o), 0);
    cycles_to_sof(n);
    check("R3", "master sof spacing", n, 160);
    wait_edge(7);
    rx_sof_i = 1; step(); rx_sof_i = 0;
    check("R3", "rx_sof ignored on master: counter", int'(us_count_o), 7);
    check("R3", "rx_sof ignored on master: sof", int'(sof_o), 0);
  endtask

  task automatic t_slave();
    int n;
    do_reset(0, 0, 0, 16'd4);
    cycles_to_sof(n);
    cycles_to_sof(n);
    check("R5", "slave free-run spacing", n, 160);
    wait_edge(15);
    rx_sof_i = 1; step(); rx_sof_i = 0;
    check("R4", "sof after rx_sof", int'(sof_o), 1);
    check("R4", "counter after rx_sof", int'(us_count_o), 0);
    cycles_to_sof(n);
    check("R5", "spacing after resync", n, 160);
  endtask

  task automatic t_window();
    int n;
    int g;
    do_reset(0, 0, 0, 16'd4);
    wait_edge(5);
    tx_req_i = 1;
    n = 0;
    do begin step(); n++; end while (!tx_grant_o && n < 400);
    check("R6", "grant at window start", int'(us_count_o), 10);
    tx_req_i = 0;
    tx_eof_i = 1; step(); tx_eof_i = 0;
    cycles_to_sof(n);
    wait_edge(20);
    tx_req_i = 1; g = 0;
    do begin step(); g += int'(tx_grant_o); end while (us_count_o != 39);
    tx_req_i = 0;
    check("R6", "no grant at/after window end", g, 0);
    do_reset(1, 0, 0, 16'd4);
    wait_edge(2);
    tx_req_i = 1; step();
    check("R6", "master start bound is 0: grant", int'(tx_grant_o), 1);
    check("R6", "master grant counter", int'(us_count_o), 2);
    tx_req_i = 0;
  endtask

  task automatic t_once();
    int n;
    int g;
    do_reset(0, 0, 0, 16'd4);
    wait_edge(9);
    tx_req_i = 1;
    n = 0;
    do begin step(); n++; end while (!tx_grant_o && n < 400);
    check("R8", "busy with grant", int'(tx_busy_o), 1);
    step();
    check("R8", "grant is one cycle", int'(tx_grant_o), 0);
    wait_edge(12);
    tx_eof_i = 1; step(); tx_eof_i = 0;
    check("R8", "busy falls after eof", int'(tx_busy_o), 0);
    g = 0;
    do begin step(); g += int'(tx_grant_o); end while (us_count_o != 20);
    check("R7", "second grant in same superframe", g, 0);
    n = 0;
    do begin step(); n++; end while (!tx_grant_o && n < 400);
    check("R7", "grant in next superframe at us", int'(us_count_o), 10);
    wait_edge(25);
    check("R8", "busy past window end", int'(tx_busy_o), 1);
    tx_req_i = 0;
    tx_eof_i = 1; step(); tx_eof_i = 0;
    check("R8", "busy clears after late eof", int'(tx_busy_o), 0);
  endtask

  task automatic t_cont();
    do_reset(0, 1, 0, 16'd4);
    wait_edge(30);
    tx_req_i = 1; step();
    check("R9", "grant outside window", int'(tx_grant_o), 1);
    tx_eof_i = 1; step(); tx_eof_i = 0;
    step();
    check("R9", "regrant same superframe", int'(tx_grant_o), 1);
    tx_req_i = 0;
  endtask

  task automatic t_rx();
    do_reset(0, 0, 0, 16'd4);
    wait_edge(2);
    rx_start_i = 1; step(); rx_start_i = 0;
    check("R10", "no accept before rx window", int'(rx_accept_o), 0);
    check("R10", "not busy before rx window", int'(rx_busy_o), 0);
    wait_edge(6);
    rx_start_i = 1; step(); rx_start_i = 0;
    check("R10", "accept in rx window", int'(rx_accept_o), 1);
    check("R10", "rx busy", int'(rx_busy_o), 1);
    rx_eof_i = 1; step(); rx_eof_i = 0;
    check("R10", "rx busy clears", int'(rx_busy_o), 0);
  endtask

  task automatic t_duplex();
    int g;
    do_reset(0, 0, 0, 16'd4);
    wait_edge(10);
    rx_start_i = 1; tx_req_i = 1; step(); rx_start_i = 0;
    check("R11", "half duplex tie: accept", int'(rx_accept_o), 1);
    check("R11", "half duplex tie: no grant", int'(tx_grant_o), 0);
    g = 0;
    for (int i = 0; i < 4; i++) begin step(); g += int'(tx_grant_o); end
    check("R11", "no grant while rx busy", g, 0);
    rx_eof_i = 1; step(); rx_eof_i = 0;
    step();
    check("R11", "grant after rx ends", int'(tx_grant_o), 1);
    tx_req_i = 0;
    wait_edge(12);
    rx_start_i = 1; step(); rx_start_i = 0;
    check("R11", "no accept while tx busy", int'(rx_accept_o), 0);
    do_reset(0, 0, 1, 16'd4);
    wait_edge(10);
    rx_start_i = 1; tx_req_i = 1; step();
    rx_start_i = 0; tx_req_i = 0;
    check("R11", "full duplex: accept", int'(rx_accept_o), 1);
    check("R11", "full duplex: grant", int'(tx_grant_o), 1);
  endtask

  initial begin
    t_reset();
    t_divider();
    t_master();
    t_slave();
    t_window();
    t_once();
    t_cont();
    t_rx();
    t_duplex();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule